// File: doc/BRIEF.md
# Calendar Clock Counter with Leap Years

This block keeps wall-clock time and a calendar date as BCD counters: seconds, minutes, hours, day of month, month and a two-digit year spanning 2000 to 2099. It also exposes a half-second status bit. A single-cycle tick pulse at 32.768 kHz goes into a two-stage prescaler. The prescaler yields half-second and one-second events, and the one-second event ripples through the calendar fields within the same clock.

Software sets the time through one write port per field. Each port has its own strobe. A written field takes its new value on the clock of the write, and counting goes on from that value even while the block is running. A write to the minutes or the seconds field clears both prescaler stages, so the next second starts exactly then. A write to the seconds field also clears the half-second bit, which cannot be written directly. A sync flag goes high a fixed number of ticks before each seconds carry, which tells software when the fields are about to change.

Top module: `cal_clock_top`

## Requirements
- R1: After synchronous reset the fields read year 00, month 01, day 01, 00:00:00, with the half-second bit at 0 and the sync flag at 0.
- R2: While run_en is high, each tick advances the prescaler. The half-second bit toggles every PRE_LO*PRE_HI ticks, and the seconds field advances when the half-second bit falls. While run_en is low, ticks are ignored and no field or the half-second bit changes unless it is written.
- R3: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each one wraps to 00 and carries into the next coarser field in the same clock.
- R4: The day field counts from 01. After day 31 it wraps to 01 and advances the month for months 01, 03, 05, 07, 08, 10 and 12. After day 30 it does the same for months 04, 06, 09 and 11.
- R5: In February the day wraps after 29 when the year is divisible by 4 and after 28 otherwise. Year 00 counts as a leap year.
- R6: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: A write strobe loads its field on the clock edge where the strobe is sampled. The write takes priority over any increment of that field in the same clock, and counting then continues from the written value.
- R8: A minutes or seconds write clears both prescaler stages. It also cancels any seconds carry that would have happened in the same clock.
- R9: The half-second bit is cleared by a seconds write only. A minutes write leaves it unchanged.
- R10: The sync flag is high exactly when run_en is high, the half-second bit is 1, and no more than SYNC_LEAD ticks remain before the next seconds carry. It is low in the clock after the carry.
- R11: Writes take effect while run_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enables counting |
| tick_in | input | 1 | Single-cycle 32.768 kHz tick pulse |
| wr_sec | input | 1 | Seconds write strobe |
| sec_wd | input | 8 | Seconds write data (BCD) |
| wr_min | input | 1 | Minutes write strobe |
| min_wd | input | 8 | Minutes write data (BCD) |
| wr_hour | input | 1 | Hours write strobe |
| hour_wd | input | 8 | Hours write data (BCD) |
| wr_day | input | 1 | Day write strobe |
| day_wd | input | 8 | Day write data (BCD) |
| wr_month | input | 1 | Month write strobe |
| month_wd | input | 8 | Month write data (BCD) |
| wr_year | input | 1 | Year write strobe |
| year_wd | input | 8 | Year write data (BCD) |
| sec_o | output | 8 | Seconds (BCD) |
| min_o | output | 8 | Minutes (BCD) |
| hour_o | output | 8 | Hours (BCD) |
| day_o | output | 8 | Day of month (BCD) |
| month_o | output | 8 | Month (BCD) |
| year_o | output | 8 | Year within 2000-2099 (BCD) |
| half_o | output | 1 | Half-second status bit |
| sync_o | output | 1 | Rollover-imminent flag |

## Verification
Two events can land in the same clock: a software write and a seconds carry that ripples through the fields. The bench reproduces this by watching its own model of the prescaler. On the clock edge where the final tick of a second is due, it raises an hours write in one case and a minutes write in the other. The hours write must win over the carried hour while seconds and minutes still wrap. The minutes write must cancel the carry, so seconds keep their value. Every output is compared with the model on every clock, so writes issued at other phases are judged the same way.

// File: rtl/cal_pkg.sv
// Package: shared BCD helpers for the calendar clock.
// Assumes all field values are two-digit packed BCD.
package cal_pkg;

    // Advance a two-digit BCD value by one (no range wrap here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when a BCD year within 00..99 is divisible by four.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [7:0] bin;
        bin = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Module: two-stage tick prescaler plus half-second bit.
// Produces a one-cycle pulse on the tick that completes a second.
// Assumes tick_in is a single-cycle pulse; PRE_LO and PRE_HI are >= 2.
module cal_prescaler #(
    parameter int PRE_LO    = 256,
    parameter int PRE_HI    = 64,
    parameter int SYNC_LEAD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick_in,
    input  logic clr_all,   // clear both stages, cancel pulse
    input  logic clr_half,  // also clear the half-second bit
    output logic sec_pulse,
    output logic half_o,
    output logic sync_o
);
    localparam int LW         = $clog2(PRE_LO);
    localparam int HW         = $clog2(PRE_HI);
    localparam int HALF_TICKS = PRE_LO * PRE_HI;
    localparam int SYNC_FROM  = (HALF_TICKS > SYNC_LEAD) ? HALF_TICKS - SYNC_LEAD : 0;

    logic [LW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic          half_q;
    logic          lo_end, hi_end, adv;
    logic [31:0]   pos;

    assign adv    = run_en && tick_in && !clr_all;
    assign lo_end = (lo_q == LW'(PRE_LO - 1));
    assign hi_end = (hi_q == HW'(PRE_HI - 1));

    // Seconds event: last tick of the second half.
    assign sec_pulse = adv && lo_end && hi_end && half_q;

    // Ticks elapsed within the current half second.
    assign pos    = 32'(hi_q) * 32'(PRE_LO) + 32'(lo_q);
    assign sync_o = run_en && half_q && (pos >= 32'(SYNC_FROM));
    assign half_o = half_q;

    // Prescaler stages and half-second bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            half_q <= 1'b0;
        end else if (clr_all) begin
            lo_q <= '0;
            hi_q <= '0;
            if (clr_half) half_q <= 1'b0;
        end else if (adv) begin
            if (lo_end) begin
                lo_q <= '0;
                if (hi_end) begin
                    hi_q   <= '0;
                    half_q <= ~half_q;
                end else begin
                    hi_q <= hi_q + HW'(1);
                end
            end else begin
                lo_q <= lo_q + LW'(1);
            end
        end
    end

    // R8: a minutes/seconds write leaves both stages at zero.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (lo_q == '0) && (hi_q == '0));

    // R9: a seconds write leaves the half-second bit low.
    assert_half_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && clr_half) |=> !half_o);

    // R10: the flag is down right after the seconds event.
    assert_sync_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sync_o);

endmodule

// File: rtl/cal_month_days.sv
// Module: last valid day (BCD) of the given month and year.
// Assumes month in 01..12; any other code is treated as 31 days.
module cal_month_days (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_day
);
    import cal_pkg::*;

    // Month-length lookup with February leap adjustment.
    always_comb begin
        unique case (month_i)
            8'h02:                      last_day = bcd_leap(year_i) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_field.sv
// Module: one BCD calendar field with write port and wrap limit.
// Increments on inc, wraps to FLOOR_V past lim, write has priority.
// Assumes lim and the stored value are valid BCD.
module cal_field #(
    parameter logic [7:0] FLOOR_V = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic [7:0] lim,
    output logic [7:0] value,
    output logic       carry
);
    import cal_pkg::*;

    logic [7:0] val_q;

    assign carry = inc && (val_q >= lim);
    assign value = val_q;

    // Field register: write, wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= FLOOR_V;
        else if (wr)     val_q <= wdata;
        else if (carry)  val_q <= FLOOR_V;
        else if (inc)    val_q <= bcd_inc(val_q);
    end

    // R7: a write lands on the next clock regardless of increments.
    assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> value == $past(wdata));

endmodule

// File: rtl/cal_clock_top.sv
// Module: calendar clock counter, 2000-2099, with leap years.
// Chains prescaler and six BCD fields; the seconds event ripples
// through all fields in one clock. Assumes tick_in is synchronous.
module cal_clock_top #(
    parameter int PRE_LO    = 256,
    parameter int PRE_HI    = 64,
    parameter int SYNC_LEAD = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       tick_in,
    input  logic       wr_sec,
    input  logic [7:0] sec_wd,
    input  logic       wr_min,
    input  logic [7:0] min_wd,
    input  logic       wr_hour,
    input  logic [7:0] hour_wd,
    input  logic       wr_day,
    input  logic [7:0] day_wd,
    input  logic       wr_month,
    input  logic [7:0] month_wd,
    input  logic       wr_year,
    input  logic [7:0] year_wd,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] day_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       half_o,
    output logic       sync_o
);
    localparam int NF = 6;

    logic          sec_pulse;
    logic [7:0]    day_lim;
    logic [NF-1:0] inc_v, wr_v, cy_v;
    logic [7:0]    wd_v  [NF];
    logic [7:0]    lim_v [NF];
    logic [7:0]    val_v [NF];

    cal_prescaler #(
        .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .SYNC_LEAD(SYNC_LEAD)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_in(tick_in),
        .clr_all(wr_sec | wr_min), .clr_half(wr_sec),
        .sec_pulse(sec_pulse), .half_o(half_o), .sync_o(sync_o)
    );

    cal_month_days u_mdays (
        .month_i(val_v[4]), .year_i(val_v[5]), .last_day(day_lim)
    );

    // Field order 0..5: sec, min, hour, day, month, year.
    assign wr_v  = {wr_year, wr_month, wr_day, wr_hour, wr_min, wr_sec};
    assign wd_v  = '{sec_wd, min_wd, hour_wd, day_wd, month_wd, year_wd};
    assign lim_v = '{8'h59, 8'h59, 8'h23, day_lim, 8'h12, 8'h99};

    // Carry chain: each field counts on the carry of the finer one.
    assign inc_v = {cy_v[NF-2:0], sec_pulse};

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_fld
            localparam logic [7:0] FLOOR = (g == 3 || g == 4) ? 8'h01 : 8'h00;
            cal_field #(.FLOOR_V(FLOOR)) u_fld (
                .clk(clk), .rst_n(rst_n), .inc(inc_v[g]), .wr(wr_v[g]),
                .wdata(wd_v[g]), .lim(lim_v[g]),
                .value(val_v[g]), .carry(cy_v[g])
            );
        end
    endgenerate

    assign sec_o   = val_v[0];
    assign min_o   = val_v[1];
    assign hour_o  = val_v[2];
    assign day_o   = val_v[3];
    assign month_o = val_v[4];
    assign year_o  = val_v[5];

    // R2: with counting off and no writes, nothing moves.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_v == '0) |=> $stable({sec_o, min_o, hour_o, day_o, month_o, year_o, half_o}));

    // R3: seconds 59 on a seconds event becomes 00 and minutes move.
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && sec_o == 8'h59) |=> (sec_o == 8'h00) && (min_o != $past(min_o)));

    // R4: a day carry without a day write returns the day to 01.
    assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_v[3] && !wr_day) |=> day_o == 8'h01);

    // R6: year 99 wraps to 00 on a month carry.
    assert_new_year_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_v[4] && !wr_year && year_o == 8'h99) |=> year_o == 8'h00);

endmodule

// File: tb/sim_cal_clock_top.sv
// Bench: behavioural cycle model compared with every output each clock.
module sim_cal_clock_top;
    localparam int L = 4, H = 4, LEAD = 6;

    logic clk = 0, rst_n = 0, run_en = 0, tick_in = 0, tick_gen = 0;
    logic wr_sec = 0, wr_min = 0, wr_hour = 0, wr_day = 0, wr_month = 0, wr_year = 0;
    logic [7:0] sec_wd = 0, min_wd = 0, hour_wd = 0, day_wd = 0, month_wd = 0, year_wd = 0;
    logic [7:0] sec_o, min_o, hour_o, day_o, month_o, year_o;
    logic half_o, sync_o;

    int checks = 0, errors = 0;
    bit cmp_on = 0;
    int m_lo, m_hi, m_half, m_sec, m_min, m_hr, m_day, m_mon, m_yr;

    cal_clock_top #(.PRE_LO(L), .PRE_HI(H), .SYNC_LEAD(LEAD)) u0 (.*);

    always #10 clk = ~clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Tick generator: alternate-cycle pulses, changed after the edge.
    always @(posedge clk) begin
        #3;
        tick_in <= tick_gen ? ~tick_in : 1'b0;
    end

    // Reference model, stepped on each edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_half = 0;
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
        end else begin
            bit wms, st, cs, cm, ch, cd, cmo;
            wms = wr_sec || wr_min;
            st  = run_en && tick_in && !wms && m_half == 1 && m_lo == L-1 && m_hi == H-1;
            cs  = st && m_sec >= 59;
            cm  = cs && m_min >= 59;
            ch  = cm && m_hr >= 23;
            cd  = ch && m_day >= dim(m_mon, m_yr);
            cmo = cd && m_mon >= 12;
            if (wms) begin
                m_lo = 0; m_hi = 0;
                if (wr_sec) m_half = 0;
            end else if (run_en && tick_in) begin
                if (m_lo == L-1) begin
                    m_lo = 0;
                    if (m_hi == H-1) begin m_hi = 0; m_half ^= 1; end
                    else m_hi++;
                end else m_lo++;
            end
            if (cmo) m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
            if (cd)  m_mon = cmo ? 1 : m_mon + 1;
            if (ch)  m_day = cd ? 1 : m_day + 1;
            if (cm)  m_hr = ch ? 0 : m_hr + 1;
            if (cs)  m_min = cm ? 0 : m_min + 1;
            if (st)  m_sec = cs ? 0 : m_sec + 1;
            if (wr_year)  m_yr  = b2i(year_wd);
            if (wr_month) m_mon = b2i(month_wd);
            if (wr_day)   m_day = b2i(day_wd);
            if (wr_hour)  m_hr  = b2i(hour_wd);
            if (wr_min)   m_min = b2i(min_wd);
            if (wr_sec)   m_sec = b2i(sec_wd);
        end
    end

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            int pos;
            pos = m_hi * L + m_lo;
            chk("R3 sec", sec_o, i2b(m_sec));
            chk("R3 min", min_o, i2b(m_min));
            chk("R3 hour", hour_o, i2b(m_hr));
            chk("R4/R5 day", day_o, i2b(m_day));
            chk("R6 month", month_o, i2b(m_mon));
            chk("R6 year", year_o, i2b(m_yr));
            chk("R9 half", half_o, m_half);
            chk("R10 sync", sync_o, (run_en && m_half == 1 && pos >= L*H - LEAD) ? 1 : 0);
        end
    end

    // Single-cycle write of one field: 0 sec .. 5 year.
    task automatic put(input int f, input logic [7:0] d);
        @(posedge clk); #4;
        case (f)
            0: begin wr_sec = 1;   sec_wd = d;   end
            1: begin wr_min = 1;   min_wd = d;   end
            2: begin wr_hour = 1;  hour_wd = d;  end
            3: begin wr_day = 1;   day_wd = d;   end
            4: begin wr_month = 1; month_wd = d; end
            default: begin wr_year = 1; year_wd = d; end
        endcase
        @(posedge clk); #4;
        {wr_sec, wr_min, wr_hour, wr_day, wr_month, wr_year} = '0;
    endtask

    task automatic set_all(input logic [7:0] y, mo, d, h, mi, s);
        put(5, y); put(4, mo); put(3, d); put(2, h); put(1, mi); put(0, s);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_date(input string tag, input logic [7:0] y, mo, d, h, mi, s);
        chk({tag, " year"}, year_o, y);   chk({tag, " month"}, month_o, mo);
        chk({tag, " day"}, day_o, d);     chk({tag, " hour"}, hour_o, h);
        chk({tag, " min"}, min_o, mi);    chk({tag, " sec"}, sec_o, s);
    endtask

    // Wait until the next edge will see the last tick of a second.
    task automatic wait_carry_edge();
        do begin
            @(posedge clk); #4;
        end while (!(tick_in && m_half == 1 && m_lo == L-1 && m_hi == H-1));
    endtask

    // Watchdog.
    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s0;
        logic h0;
        repeat (3) @(posedge clk);
        #4 rst_n = 1;
        @(negedge clk);
        chk_date("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        chk("R1 half", half_o, 0);
        chk("R1 sync", sync_o, 0);
        cmp_on = 1;

        // R2: counting from an aligned start.
        @(posedge clk); #4 run_en = 1; tick_gen = 1;
        put(0, 8'h10);
        wait_cyc(70);
        chk("R2 one second", sec_o, 8'h11);
        wait_cyc(64);
        chk("R2 two seconds", sec_o, 8'h12);

        // R4 / R5 / R6: month, leap and year rollovers.
        set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R5 common Feb", 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
        set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R5 leap Feb28", 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
        put(2, 8'h23); put(1, 8'h59); put(0, 8'h58); wait_cyc(140);
        chk_date("R5 leap Feb29", 8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
        set_all(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R5 year00 leap", 8'h00, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
        set_all(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R4 Apr30", 8'h23, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
        set_all(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R4 Jan30", 8'h23, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00);
        set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58); wait_cyc(140);
        chk_date("R6 century", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);

        // R7: hour write on the very edge of a full rollover.
        put(2, 8'h22); put(1, 8'h59); put(0, 8'h59);
        wait_carry_edge();
        wr_hour = 1; hour_wd = 8'h07;
        @(posedge clk); #4 wr_hour = 0;
        @(negedge clk);
        chk("R7 hour write wins", hour_o, 8'h07);
        chk("R7 sec wrapped", sec_o, 8'h00);
        chk("R7 min wrapped", min_o, 8'h00);
        wait_cyc(64);
        chk("R7 counts on", sec_o, 8'h01);

        // R8: minutes write on the carry edge cancels the carry.
        put(0, 8'h59);
        wait_carry_edge();
        wr_min = 1; min_wd = 8'h33;
        @(posedge clk); #4 wr_min = 0;
        @(negedge clk);
        chk("R8 sec held", sec_o, 8'h59);
        chk("R8 min written", min_o, 8'h33);
        chk("R8 half kept", half_o, 1);

        // R9: minutes write keeps half bit, seconds write clears it.
        do begin @(posedge clk); #4; end while (m_half != 1);
        h0 = half_o;
        put(1, 8'h12);
        @(negedge clk);
        chk("R9 min write keeps half", half_o, h0);
        put(0, 8'h05);
        @(negedge clk);
        chk("R9 sec write clears half", half_o, 0);

        // R11 / R2: writes while stopped, ticks ignored.
        @(posedge clk); #4 run_en = 0;
        put(3, 8'h15);
        @(negedge clk);
        chk("R11 write while stopped", day_o, 8'h15);
        s0 = sec_o;
        wait_cyc(150);
        chk("R2 stopped sec", sec_o, s0);
        chk("R10 sync low stopped", sync_o, 0);

        // Writes at many phases while running.
        @(posedge clk); #4 run_en = 1;
        for (int k = 0; k < 40; k++) begin
            put(2 + (k % 4), i2b(1 + (k % 9)));
            repeat (k % 5) @(posedge clk);
        end
        wait_cyc(100);

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule